// File: doc/BRIEF.md
# Dual-Plane Page-Write Sequencer with Busy Polling

This block sits behind a byte-wide bus slave and controls how a byte-addressed nonvolatile array is updated. The array is split into two equal planes by the top address bit and into eight equal protection blocks by the top three address bits. A write must be preceded by three fixed unlock writes. After that, data bytes collect in a 32-entry page buffer until the bus has been quiet for a load window. The buffer is then committed during a programming phase of fixed length. With the default `ADDR_W` of 11, the array is 2 KB. The 8 KB arrangement, with plane select on bit 12, is `ADDR_W = 13`.

While a page is loading or programming, a read into that page's plane is a status poll: bit 6 of the returned byte inverts on every such read. A read into the other plane returns true data, so code can keep running from one plane while the other is updated. A write-lock input blocks every write and throws away a page that has not started programming. An 8-bit mask locks individual blocks against data writes. The array itself is modelled as a plain RAM.

Top module: `nvpage_ctrl`

## Requirements
- R1: Data bytes are accepted only after three writes in order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), given as address, data. A write that breaks the order returns the sequence to its start and is otherwise ignored, including every following byte up to the next complete unlock.
- R2: All bytes of one page share address bits `ADDR_W-1` down to 5. Bits 4..0 pick the byte within the page. A page holds 1 to 32 bytes, and after programming each byte reads back at its own address.
- R3: `busy` rises exactly `LOAD_CYC` clock edges after the edge that took the last accepted data byte. Each accepted byte restarts this count.
- R4: `busy` stays high for exactly `PROG_CYC` edges. Afterwards only the byte positions that were loaded hold new data, and the other positions in the page keep their old contents.
- R5: A read whose top address bit equals that of the open page, issued while the page is loading or programming, returns bit 6 inverted relative to the previous such read. Once `busy` falls, reads return the stored byte unchanged.
- R6: A read returns data on `rd_data` with `rd_valid` high one edge after the request. A read into the plane that is not being written returns the stored byte, even while `busy` is high.
- R7: While `wr_lock` is high, every write is ignored and does not advance the unlock sequence. If `wr_lock` is high while unlocked or loading, the pending page is discarded and no programming starts.
- R8: Bit i of `prot_mask` locks block i, the block being address bits `ADDR_W-1` down to `ADDR_W-3`. A data byte addressed into a locked block is not loaded and does not start the load window. Any combination of bits may be set.
- R9: A write arriving while `busy` is high, or a data byte whose page bits differ from the open page, is dropped and sets `err`. `err` stays high until reset.
- R10: After reset, `busy`, `err` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| wr_lock | input | 1 | High blocks writes and aborts a pending page |
| prot_mask | input | 8 | Per-block write lock |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Programming in progress |
| err | output | 1 | Sticky dropped-write flag |

## Verification
Every result is tied to an edge count from its stimulus. Read data appears one edge after the request, and `err` one edge after the offending write. `busy` rises `LOAD_CYC` edges after the last accepted byte and falls `PROG_CYC` edges later. The bench drives inputs and samples outputs on falling edges. Its timing checks count that exact number of falling edges after the write task returns, checking one edge before and one edge on the expected change. Outcomes that must not happen are checked by waiting longer than a full load window, then reading back through the bus.

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl #(
  parameter int ADDR_W   = 11,
  parameter int LOAD_CYC = 20,
  parameter int PROG_CYC = 40,
  parameter logic [ADDR_W-1:0] U0_A = 'h555,
  parameter logic [7:0]        U0_D = 8'hAA,
  parameter logic [ADDR_W-1:0] U1_A = 'h2AA,
  parameter logic [7:0]        U1_D = 8'h55,
  parameter logic [ADDR_W-1:0] U2_A = 'h555,
  parameter logic [7:0]        U2_D = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              wr_lock,
  input  logic [7:0]        prot_mask,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              err
);
  localparam int PG_W   = 5;
  localparam int PAGE_N = 1 << PG_W;
  localparam int TAG_W  = ADDR_W - PG_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TMAX   = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int TMR_W  = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_LOAD, S_PROG} st_t;

  st_t               st;
  logic [1:0]        ucnt;
  logic [TMR_W-1:0]  tmr;
  logic [PG_W:0]     cnt;
  logic [TAG_W-1:0]  ptag;
  logic [PAGE_N-1:0] pvld;
  logic              tog, tog_q, poll_q;
  logic [7:0]        raw_q;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE_N];

  wire wr      = bus_valid & bus_we & ~wr_lock;
  wire rd      = bus_valid & ~bus_we;
  wire prot    = prot_mask[bus_addr[ADDR_W-1 -: 3]];
  wire same_pg = bus_addr[ADDR_W-1:PG_W] == ptag;
  wire pair_ok = (ucnt == 2'd0) ? (bus_addr == U0_A && bus_wdata == U0_D) :
                 (ucnt == 2'd1) ? (bus_addr == U1_A && bus_wdata == U1_D) :
                                  (bus_addr == U2_A && bus_wdata == U2_D);
  wire take    = wr & ~prot & ((st == S_ARM) | (st == S_LOAD & same_pg));
  wire bad     = wr & ((st == S_PROG) | (st == S_LOAD & ~same_pg));
  wire poll    = rd & (st == S_LOAD | st == S_PROG) & (bus_addr[ADDR_W-1] == ptag[TAG_W-1]);
  wire mem_we  = (st == S_PROG) & ~cnt[PG_W] & pvld[cnt[PG_W-1:0]];

  assign busy    = st == S_PROG;
  assign rd_data = poll_q ? {raw_q[7], tog_q, raw_q[5:0]} : raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ucnt <= '0; tmr <= '0; cnt <= '0; ptag <= '0;
      pvld <= '0; err <= 1'b0; tog <= 1'b0; tog_q <= 1'b0;
      poll_q <= 1'b0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd;
      poll_q   <= poll;
      tog_q    <= tog;
      if (poll) tog <= ~tog;
      if (bad) err <= 1'b1;
      if (take) pvld[bus_addr[PG_W-1:0]] <= 1'b1;
      case (st)
        S_IDLE: if (wr) begin
          if (!pair_ok) ucnt <= '0;
          else if (ucnt == 2'd2) begin ucnt <= '0; st <= S_ARM; end
          else ucnt <= ucnt + 2'd1;
        end
        S_ARM: begin
          if (wr_lock) st <= S_IDLE;
          else if (take) begin
            st   <= S_LOAD;
            ptag <= bus_addr[ADDR_W-1:PG_W];
            tmr  <= TMR_W'(LOAD_CYC);
          end
        end
        S_LOAD: begin
          if (wr_lock) begin st <= S_IDLE; pvld <= '0; end
          else if (take) tmr <= TMR_W'(LOAD_CYC);
          else if (tmr == TMR_W'(1)) begin
            st <= S_PROG; tmr <= TMR_W'(PROG_CYC); cnt <= '0;
          end else tmr <= tmr - TMR_W'(1);
        end
        S_PROG: begin
          if (!cnt[PG_W]) cnt <= cnt + 1'b1;
          if (tmr == TMR_W'(1)) begin st <= S_IDLE; pvld <= '0; end
          else tmr <= tmr - TMR_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[bus_addr[PG_W-1:0]] <= bus_wdata;
    if (mem_we) mem[{ptag, cnt[PG_W-1:0]}] <= pbuf[cnt[PG_W-1:0]];
    if (rd) raw_q <= mem[bus_addr];
  end

  p_unlock_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !(bus_valid && bus_we)) |=> $stable(ucnt));
  p_prog_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st == S_LOAD));
  p_all_walked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt[PG_W]);
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |=> rd_valid);
  p_lock_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && wr_lock) |=> (st == S_IDLE && pvld == '0));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/nvpage_ctrl_tb.sv
module nvpage_ctrl_tb;
  localparam int AW = 11;
  localparam int L  = 20;
  localparam int P  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0, wr_lock = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, prot_mask = '0;
  logic rd_valid, busy, err;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [int];

  always #2.5 clk = ~clk;

  nvpage_ctrl #(.ADDR_W(AW), .LOAD_CYC(L), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_lock(wr_lock),
    .prot_mask(prot_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .err(err));

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = rd_data;
    chk(rd_valid === 1'b1, "R6 rd_valid", int'(rd_valid), 1);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
  endtask

  task automatic settle();
    repeat (L + P + 4) @(negedge clk);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(d === exp_mem[int'(a)], tag, int'(d), int'(exp_mem[int'(a)]));
  endtask

  task automatic t_reset();
    chk(busy === 0 && err === 0 && rd_valid === 0, "R10 reset outputs",
        int'({busy, err, rd_valid}), 0);
  endtask

  task automatic t_basic();
    unlock();
    for (int i = 0; i < 8; i++) wr(AW'(11'h040 + i), 8'(8'h10 + i));
    repeat (L - 1) @(negedge clk);
    chk(busy === 0, "R3 busy before window end", int'(busy), 0);
    @(negedge clk);
    chk(busy === 1, "R3 busy at window end", int'(busy), 1);
    repeat (P - 1) @(negedge clk);
    chk(busy === 1, "R4 busy before prog end", int'(busy), 1);
    @(negedge clk);
    chk(busy === 0, "R4 busy at prog end", int'(busy), 0);
    for (int i = 0; i < 8; i++) exp_mem[16'h040 + i] = 8'(8'h10 + i);
    for (int i = 0; i < 8; i++) rd_exp(AW'(11'h040 + i), "R2 page readback");
    unlock();
    for (int i = 0; i < 8; i++) wr(AW'(11'h440 + i), 8'(8'h30 + i));
    settle();
    for (int i = 0; i < 8; i++) exp_mem[16'h440 + i] = 8'(8'h30 + i);
    rd_exp(11'h445, "R2 plane1 readback");
  endtask

  task automatic t_restart();
    unlock();
    wr(11'h050, 8'h01);
    repeat (L - 3) @(negedge clk);
    wr(11'h051, 8'h02);
    repeat (L - 1) @(negedge clk);
    chk(busy === 0, "R3 window restarted", int'(busy), 0);
    @(negedge clk);
    chk(busy === 1, "R3 busy after restarted window", int'(busy), 1);
    settle();
    exp_mem[16'h050] = 8'h01; exp_mem[16'h051] = 8'h02;
    rd_exp(11'h051, "R3 restart data");
  endtask

  task automatic t_partial();
    unlock();
    wr(11'h041, 8'hA5);
    settle();
    exp_mem[16'h041] = 8'hA5;
    for (int i = 0; i < 8; i++) rd_exp(AW'(11'h040 + i), "R4 partial commit");
  endtask

  task automatic t_poll();
    logic [7:0] d1, d2, d3, d4;
    unlock();
    wr(11'h060, 8'h3C);
    rd(11'h060, d1);
    rd(11'h061, d2);
    chk(d1[6] !== d2[6], "R5 toggle while loading", int'(d2[6]), int'(~d1[6]));
    for (int i = 0; i < 4 * L && !busy; i++) @(negedge clk);
    chk(busy === 1, "R3 programming started", int'(busy), 1);
    rd(11'h060, d3);
    chk(d3[6] !== d2[6], "R5 toggle across phases", int'(d3[6]), int'(~d2[6]));
    rd(11'h047, d4);
    chk(d4[6] !== d3[6], "R5 toggle while busy", int'(d4[6]), int'(~d3[6]));
    rd_exp(11'h443, "R6 other plane true data");
    chk(busy === 1, "R6 read taken while busy", int'(busy), 1);
    settle();
    exp_mem[16'h060] = 8'h3C;
    rd_exp(11'h060, "R5 toggling stopped 1");
    rd_exp(11'h060, "R5 toggling stopped 2");
  endtask

  task automatic t_unlock_bad();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h11); wr(11'h555, 8'hA0);
    wr(11'h042, 8'h77);
    repeat (L + 2) @(negedge clk);
    chk(busy === 0, "R1 no programming without unlock", int'(busy), 0);
    rd_exp(11'h042, "R1 byte ignored");
  endtask

  task automatic t_lock();
    unlock();
    wr(11'h043, 8'h99);
    @(negedge clk); wr_lock = 1;
    @(negedge clk); wr_lock = 0;
    repeat (L + 2) @(negedge clk);
    chk(busy === 0, "R7 page discarded", int'(busy), 0);
    rd_exp(11'h043, "R7 discarded data");
    @(negedge clk); wr_lock = 1;
    unlock();
    wr(11'h043, 8'h98);
    @(negedge clk); wr_lock = 0;
    wr(11'h043, 8'h97);
    repeat (L + 2) @(negedge clk);
    chk(busy === 0, "R7 locked writes ignored", int'(busy), 0);
    rd_exp(11'h043, "R7 locked data");
  endtask

  task automatic t_protect();
    prot_mask = 8'h81;
    unlock();
    wr(11'h744, 8'h66);
    repeat (L + 2) @(negedge clk);
    chk(busy === 0, "R8 block7 locked", int'(busy), 0);
    wr(11'h044, 8'h66);
    repeat (L + 2) @(negedge clk);
    chk(busy === 0, "R8 block0 locked", int'(busy), 0);
    wr(11'h144, 8'h5A);
    settle();
    exp_mem[16'h144] = 8'h5A;
    rd_exp(11'h044, "R8 locked byte unchanged");
    rd_exp(11'h144, "R8 open block written");
    prot_mask = 8'h00;
  endtask

  task automatic t_error();
    chk(err === 0, "R9 err clear", int'(err), 0);
    unlock();
    wr(11'h048, 8'h21);
    wr(11'h068, 8'h22);
    chk(err === 1, "R9 err on page mismatch", int'(err), 1);
    settle();
    exp_mem[16'h048] = 8'h21;
    rd_exp(11'h048, "R9 good byte kept");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(err === 0 && busy === 0, "R10 reset clears err", int'({err, busy}), 0);
    unlock();
    wr(11'h049, 8'h31);
    for (int i = 0; i < 4 * L && !busy; i++) @(negedge clk);
    wr(11'h042, 8'hEE);
    chk(err === 1, "R9 err on write while busy", int'(err), 1);
    settle();
    exp_mem[16'h049] = 8'h31;
    rd_exp(11'h042, "R9 busy write dropped");
    rd_exp(11'h049, "R9 page committed");
    chk(err === 1, "R9 err sticky", int'(err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_restart();
    t_partial();
    t_poll();
    t_unlock_bad();
    t_lock();
    t_protect();
    t_error();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule